// File: doc/BRIEF.md
# E1 Transmit Timeslot-16 Signaling Inserter

This block sits in the transmit path of an E1 framer. Its host-side register file holds sixteen signaling bytes. At every transmit multiframe boundary it copies all sixteen into a snapshot buffer. The outgoing byte stream then takes its timeslot-16 content from that buffer, one entry per frame. Timeslot 16 is replaced only while insertion is enabled. Every other timeslot, and timeslot 16 while insertion is off, leaves the block unchanged, one clock later.

A sticky multiframe flag tells the host that a snapshot has just been taken and the registers may be refreshed for the next multiframe. The host only needs to rewrite the bytes that change. Entry 0 is transmitted in frame 0 and holds the multiframe alignment pattern (upper nibble 0000) plus the alarm bits (lower nibble). Entry n (1..15) carries the ABCD bits of two channels, one per nibble. The block treats each entry as an opaque byte.

A view-select input decides what host reads return. With it low, reads return a receive signaling byte taken from an input bus. With it high, reads return the transmit register contents.

Top module: `cas_tx_inserter`

## Requirements
- R1: A host write (`host_wr`=1) to index `host_waddr` stores `host_wdata` in that register at the clock edge.
- R2: `host_rdata` depends only on the current inputs and register contents. With `rd_tx_sel`=1 it equals register `host_raddr`. With `rd_tx_sel`=0 it equals `rx_sig[8*host_raddr+7 : 8*host_raddr]`.
- R3: A byte with `in_valid`=1 and `in_mf_start`=1 is a multiframe boundary. At that edge all sixteen registers are copied into the snapshot buffer. A host write in the same cycle updates the register only, and that value reaches the line at the next boundary.
- R4: Byte positions are counted from the boundary byte: timeslot 0..31 within a frame, frame 0..15 within the multiframe. While `ins_en`=1, the timeslot-16 byte of frame k is replaced by snapshot entry k, with bit 7 of the entry as bit 7 of the output byte. Entry 0 (alignment and alarm byte) goes out in frame 0.
- R5: All timeslots other than 16 pass through unchanged. Timeslot 16 also passes through unchanged while `ins_en`=0, and before the first boundary after reset.
- R6: `out_valid` and `out_byte` are registered and follow `in_valid`/`in_byte` by one cycle. While `in_valid`=0, `out_valid` is 0 on the next cycle and `out_byte` holds its value.
- R7: `mf_flag` goes to 1 on the cycle after each boundary and stays there until the host pulses `mf_clr`. If a boundary and `mf_clr` fall in the same cycle, the flag stays set.
- R8: Registers that are not written keep their values across boundaries, and are sent again in following multiframes.
- R9: After synchronous active-low reset the following are 0: all registers, the snapshot, `out_valid`, `out_byte` and `mf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 4 | Register index written |
| host_wdata | input | 8 | Write data |
| host_raddr | input | 4 | Register index read |
| rd_tx_sel | input | 1 | 1: read transmit registers, 0: read receive signaling |
| host_rdata | output | 8 | Read data (combinational) |
| rx_sig | input | 128 | Receive signaling bytes, byte i at bits 8i+7..8i |
| ins_en | input | 1 | Timeslot-16 insertion enable |
| mf_clr | input | 1 | Clears the multiframe flag |
| mf_flag | output | 1 | Sticky transmit multiframe flag |
| in_valid | input | 1 | Input byte strobe |
| in_mf_start | input | 1 | Marks frame 0, timeslot 0 |
| in_byte | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Output stream byte |

## Verification
The assertions check the following on every cycle:
- register writes take effect, and registers stay stable when not written;
- the snapshot changes only at a boundary;
- the flag sets on a boundary and clears when asked;
- the output strobe and hold timing is one cycle;
- bytes pass through while insertion is off.

Only the bench's scenarios show the rest:
- timeslot 16 of each frame carries the right snapshot entry;
- a write in the boundary cycle is deferred by a full multiframe;
- stream positions before the first boundary are not touched;
- registers left alone are sent again.

// File: rtl/cas_pkg.sv
// Shared constants and types for the timeslot-16 signaling inserter.
package cas_pkg;
    localparam int SIG_W     = 8;   // width of one signaling byte
    localparam int NUM_REGS  = 16;  // registers = frames per multiframe
    localparam int NUM_SLOTS = 32;  // timeslots per frame
    localparam int SIG_SLOT  = 16;  // timeslot carrying signaling
endpackage

// File: rtl/cas_sig_regs.sv
// Host signaling register file with a switchable read view.
// Assumes one write per cycle. Reads are combinational and pick either the
// transmit registers or a byte of the receive signaling bus.
module cas_sig_regs #(
    parameter int W     = 8,
    parameter int NREG  = 16,
    localparam int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    input  logic [AW-1:0]     raddr,
    input  logic              rd_tx_sel,
    input  logic [NREG*W-1:0] rx_sig,
    output logic [W-1:0]      rdata,
    output logic [NREG*W-1:0] regs_flat
);
    logic [W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Store the host byte when this index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr && (waddr == AW'(i)))
                regs_q[i] <= wdata;
        end
        assign regs_flat[i*W +: W] = regs_q[i];
    end

    // Read view select: transmit registers or the receive bus.
    always_comb begin
        if (rd_tx_sel)
            rdata = regs_q[raddr];
        else
            rdata = rx_sig[int'(raddr)*W +: W];
    end

    // R1: a write lands at the addressed index.
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> regs_q[$past(waddr)] == $past(wdata));
    // R8: without a write, no register changes.
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs_flat));
endmodule

// File: rtl/cas_mf_tracker.sv
// Tracks timeslot and frame position of the input stream and keeps the
// sticky multiframe flag. Assumes in_mf_start is only meaningful with
// in_valid. The position of the current byte is resolved combinationally so
// the boundary byte itself counts as frame 0, timeslot 0.
module cas_mf_tracker #(
    parameter int SLOTS  = 32,
    parameter int FRAMES = 16,
    localparam int TSW   = $clog2(SLOTS),
    localparam int FRW   = $clog2(FRAMES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           mf_start,
    input  logic           mf_clr,
    output logic           boundary,
    output logic [TSW-1:0] cur_ts,
    output logic [FRW-1:0] cur_fr,
    output logic           pos_ok,
    output logic           mf_flag
);
    logic [TSW-1:0] ts_q;
    logic [FRW-1:0] fr_q;
    logic           locked_q;

    assign boundary = in_valid && mf_start;

    // Position of the byte currently presented.
    always_comb begin
        cur_ts = mf_start ? '0 : ts_q;
        cur_fr = mf_start ? '0 : fr_q;
        pos_ok = mf_start || locked_q;
    end

    // Advance the position counters on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q     <= '0;
            fr_q     <= '0;
            locked_q <= 1'b0;
        end else if (in_valid) begin
            locked_q <= locked_q || mf_start;
            if (cur_ts == TSW'(SLOTS-1)) begin
                ts_q <= '0;
                fr_q <= (cur_fr == FRW'(FRAMES-1)) ? '0 : cur_fr + 1'b1;
            end else begin
                ts_q <= cur_ts + 1'b1;
                fr_q <= cur_fr;
            end
        end
    end

    // Sticky flag: a boundary sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mf_flag <= 1'b0;
        else if (boundary)
            mf_flag <= 1'b1;
        else if (mf_clr)
            mf_flag <= 1'b0;
    end

    // R7: the flag is set after every boundary.
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> mf_flag);
    // R7: a clear without a boundary drops the flag.
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_clr && !boundary) |=> !mf_flag);
    // R4: the byte after a boundary is timeslot 1 of frame 0.
    a_r4_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (ts_q == TSW'(1)) && (fr_q == '0));
endmodule

// File: rtl/cas_ts16_mux.sv
// Snapshot buffer and output stage. Copies the register file into the
// snapshot at each boundary and replaces the signaling timeslot with entry
// [frame] when insertion is enabled and the position is known. One-cycle
// registered output.
module cas_ts16_mux #(
    parameter int W        = 8,
    parameter int NREG     = 16,
    parameter int SLOTS    = 32,
    parameter int SIG_SLOT = 16,
    localparam int TSW     = $clog2(SLOTS),
    localparam int FRW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic [NREG*W-1:0] regs_flat,
    input  logic              in_valid,
    input  logic [W-1:0]      in_byte,
    input  logic [TSW-1:0]    cur_ts,
    input  logic [FRW-1:0]    cur_fr,
    input  logic              pos_ok,
    input  logic              ins_en,
    output logic              out_valid,
    output logic [W-1:0]      out_byte
);
    logic [W-1:0]      snap_q [NREG];
    logic [NREG*W-1:0] snap_flat;
    logic              take_sig;

    for (genvar i = 0; i < NREG; i++) begin : g_snap
        // Load this entry from its register at the boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap_q[i] <= '0;
            else if (boundary)
                snap_q[i] <= regs_flat[i*W +: W];
        end
        assign snap_flat[i*W +: W] = snap_q[i];
    end

    // Decide whether the current byte is a signaling slot to replace.
    assign take_sig = ins_en && pos_ok && (cur_ts == TSW'(SIG_SLOT));

    // Register the outgoing byte and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_byte <= take_sig ? snap_q[cur_fr] : in_byte;
        end
    end

    // R3: the snapshot only moves at a boundary.
    a_r3_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(snap_flat));
    // R5: with insertion off every byte passes through.
    a_r5_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ins_en) |=> out_byte == $past(in_byte));
    // R6: an accepted byte appears one cycle later.
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6: idle cycles hold the output byte.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_byte)));
endmodule

// File: rtl/cas_tx_inserter.sv
// Top level of the transmit timeslot-16 signaling inserter. Connects the
// host register file, the stream position tracker and the snapshot/output
// stage. Assumes a byte-wide stream with in_mf_start on frame 0, timeslot 0.
module cas_tx_inserter
    import cas_pkg::*;
#(
    parameter int W        = SIG_W,
    parameter int NREG     = NUM_REGS,
    parameter int SLOTS    = NUM_SLOTS,
    parameter int SIG_TS   = SIG_SLOT,
    localparam int AW      = $clog2(NREG),
    localparam int TSW     = $clog2(SLOTS),
    localparam int FRW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_waddr,
    input  logic [W-1:0]      host_wdata,
    input  logic [AW-1:0]     host_raddr,
    input  logic              rd_tx_sel,
    output logic [W-1:0]      host_rdata,
    input  logic [NREG*W-1:0] rx_sig,
    input  logic              ins_en,
    input  logic              mf_clr,
    output logic              mf_flag,
    input  logic              in_valid,
    input  logic              in_mf_start,
    input  logic [W-1:0]      in_byte,
    output logic              out_valid,
    output logic [W-1:0]      out_byte
);
    logic [NREG*W-1:0] regs_flat;
    logic              boundary;
    logic [TSW-1:0]    cur_ts;
    logic [FRW-1:0]    cur_fr;
    logic              pos_ok;

    cas_sig_regs #(.W(W), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .waddr     (host_waddr),
        .wdata     (host_wdata),
        .raddr     (host_raddr),
        .rd_tx_sel (rd_tx_sel),
        .rx_sig    (rx_sig),
        .rdata     (host_rdata),
        .regs_flat (regs_flat)
    );

    cas_mf_tracker #(.SLOTS(SLOTS), .FRAMES(NREG)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mf_start (in_mf_start),
        .mf_clr   (mf_clr),
        .boundary (boundary),
        .cur_ts   (cur_ts),
        .cur_fr   (cur_fr),
        .pos_ok   (pos_ok),
        .mf_flag  (mf_flag)
    );

    cas_ts16_mux #(.W(W), .NREG(NREG), .SLOTS(SLOTS), .SIG_SLOT(SIG_TS)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .regs_flat (regs_flat),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .cur_ts    (cur_ts),
        .cur_fr    (cur_fr),
        .pos_ok    (pos_ok),
        .ins_en    (ins_en),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );
endmodule

// File: tb/cas_tx_inserter_bench.sv
// Self-checking bench: a write/readback vector table, then directed stream
// tests of snapshot, insertion, pass-through, flag and timing.
module cas_tx_inserter_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic [3:0]   host_waddr = '0;
    logic [7:0]   host_wdata = '0;
    logic [3:0]   host_raddr = '0;
    logic         rd_tx_sel = 1'b0;
    logic [7:0]   host_rdata;
    logic [127:0] rx_sig = '0;
    logic         ins_en = 1'b0;
    logic         mf_clr = 1'b0;
    logic         mf_flag;
    logic         in_valid = 1'b0;
    logic         in_mf_start = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         out_valid;
    logic [7:0]   out_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mreg [16];
    logic [7:0] msnap [16];
    bit         mlock = 1'b0;

    // Vector table: {index, data}; entry 0 is alignment nibble 0000 + alarms.
    localparam logic [11:0] WVEC [16] = '{
        12'h00B, 12'h1A5, 12'h23C, 12'h3F0, 12'h40F, 12'h596, 12'h669, 12'h7E1,
        12'h81E, 12'h9D2, 12'hA2D, 12'hB77, 12'hC88, 12'hD4B, 12'hEB4, 12'hF99};

    cas_tx_inserter u_cas_tx_inserter (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .rd_tx_sel(rd_tx_sel),
        .host_rdata(host_rdata), .rx_sig(rx_sig), .ins_en(ins_en),
        .mf_clr(mf_clr), .mf_flag(mf_flag), .in_valid(in_valid),
        .in_mf_start(in_mf_start), .in_byte(in_byte), .out_valid(out_valid),
        .out_byte(out_byte));

    always #2.5 clk = ~clk;

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int fr, input int ts, input int seed);
        return 8'((ts * 7 + fr * 13 + seed * 31) ^ 8'h5A);
    endfunction

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0;
        mreg[a] = d;
    endtask

    // One stream byte; optional host write and flag clear in the same cycle.
    task automatic send(input logic st, input logic [7:0] d, input logic [7:0] exp,
                        input string rq, input bit bwr, input logic [3:0] ba,
                        input logic [7:0] bd, input bit clr);
        in_valid = 1'b1; in_mf_start = st; in_byte = d;
        host_wr = bwr; host_waddr = ba; host_wdata = bd; mf_clr = clr;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; in_mf_start = 1'b0; host_wr = 1'b0; mf_clr = 1'b0;
        check({rq, " byte"}, {24'b0, out_byte}, {24'b0, exp});
        check("R6 out_valid after byte", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic run_mf(input bit en, input int seed, input bit bwr,
                          input logic [3:0] ba, input logic [7:0] bd, input bit clr);
        ins_en = en;
        for (int fr = 0; fr < 16; fr++) begin
            for (int ts = 0; ts < 32; ts++) begin
                logic [7:0] d;
                logic [7:0] e;
                bit st;
                st = (fr == 0) && (ts == 0);
                d = pat(fr, ts, seed);
                if (st) begin
                    for (int i = 0; i < 16; i++) msnap[i] = mreg[i];
                    mlock = 1'b1;
                end
                e = (en && mlock && ts == 16) ? msnap[fr] : d;
                send(st, d, e, (ts == 16) ? (en ? "R4 ts16 insert" : "R5 ts16 pass")
                                          : "R5 other slot",
                     st && bwr, ba, bd, st && clr);
                if (st && bwr) mreg[ba] = bd;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mreg[i] = '0; msnap[i] = '0; end
        for (int i = 0; i < 16; i++) rx_sig[i*8 +: 8] = 8'(8'hC0 + i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 out_valid", {31'b0, out_valid}, 32'd0);
        check("R9 out_byte", {24'b0, out_byte}, 32'd0);
        check("R9 mf_flag", {31'b0, mf_flag}, 32'd0);
        rd_tx_sel = 1'b1; host_raddr = 4'd7; #1;
        check("R9 register zero", {24'b0, host_rdata}, 32'd0);

        // R1/R2: table walk, write then read back the transmit view
        for (int v = 0; v < 16; v++) host_write(WVEC[v][11:8], WVEC[v][7:0]);
        for (int v = 0; v < 16; v++) begin
            host_raddr = WVEC[v][11:8]; #1;
            check("R1 readback tx view", {24'b0, host_rdata}, {24'b0, WVEC[v][7:0]});
        end
        // R2: receive view
        rd_tx_sel = 1'b0;
        for (int v = 0; v < 16; v += 5) begin
            host_raddr = 4'(v); #1;
            check("R2 rx view", {24'b0, host_rdata}, {24'b0, 8'(8'hC0 + v * 3)});
        end
        @(negedge clk);

        // R5: before the first boundary timeslot 16 passes untouched
        ins_en = 1'b1;
        for (int k = 0; k < 40; k++)
            send(1'b0, pat(0, k, 9), pat(0, k, 9), "R5 prelock", 0, '0, '0, 0);
        check("R7 no flag before boundary", {31'b0, mf_flag}, 32'd0);

        // R4: full multiframe with insertion
        run_mf(1, 1, 0, '0, '0, 0);
        check("R7 flag sticky", {31'b0, mf_flag}, 32'd1);
        mf_clr = 1'b1; @(posedge clk); @(negedge clk); mf_clr = 1'b0;
        check("R7 flag cleared", {31'b0, mf_flag}, 32'd0);

        // R3: write and clear in the boundary cycle; snapshot keeps old value
        run_mf(1, 2, 1, 4'd5, 8'hC3, 1);
        check("R7 set wins over clear", {31'b0, mf_flag}, 32'd1);
        rd_tx_sel = 1'b1; host_raddr = 4'd5; #1;
        check("R3 boundary write landed", {24'b0, host_rdata}, 32'hC3);
        @(negedge clk);

        // R8: next multiframe shows the deferred write, other entries resent
        run_mf(1, 3, 0, '0, '0, 0);

        // R5: insertion off
        run_mf(0, 4, 0, '0, '0, 0);

        // R6: idle cycle drops out_valid and holds out_byte
        begin
            logic [7:0] last;
            last = out_byte;
            @(posedge clk); @(negedge clk);
            check("R6 idle out_valid", {31'b0, out_valid}, 32'd0);
            check("R6 idle hold", {24'b0, out_byte}, {24'b0, last});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule